// File: doc/BRIEF.md
# Single-Stream DMA Transfer Sequencer

This block is a one-channel memory-to-memory mover. Software loads a source start address, a destination start address and an item count, then sets the run bit in a control word. The sequencer then issues read requests on a simple request/ready bus and parks the returned items in a small on-chip beat buffer. It writes them back out in the same order. The control word also picks, for each side, whether the address walks forward and how wide each item is. It also picks how many reads are grouped into one incrementing burst.

The run bit drops by itself once the last item has been written. Clearing the run bit by software in the middle of a transfer throws the stream away. The state machine goes idle, both working address registers are zeroed, and the bus request is withdrawn. A width code outside the three legal values prevents the start and raises a flag that holds until reset.

Control word layout (the bus and the register port both depend on it): bit 0 run, bit 1 source walk, bit 2 destination walk, bits 4:3 source width, bits 6:5 destination width, bits 8:7 burst group. Register select: 0 control, 1 source start, 2 destination start, 3 item count.

Top module: `dma_stream_seq`

## Requirements
- R1: Writing the control word with bit 0 set while bit 0 reads 0, both width codes legal and a non-zero item count, loads the working source and destination registers from their start registers at that clock edge. Bit 0 then reads 1 and read requests begin.
- R2: After exactly item-count writes have been accepted, bit 0 returns to 0 by itself at the edge of the last write acceptance, and `bus_req` is low from then on. Exactly item-count reads are accepted.
- R3: With bit 1 set, the working source address grows by the source width in bytes at each accepted read. With bit 1 clear it holds its start value for the whole transfer.
- R4: With bit 2 set, the working destination address grows by the destination width in bytes at each accepted write. With bit 2 clear it holds its start value.
- R5: Width code 00 is 1 byte, 01 is 2 bytes and 10 is 4 bytes. Reads present the source code on `bus_size` and writes present the destination code.
- R6: Burst code 00 means 1 beat, 01 means 4, 10 means 8 and 11 means 16. While at least that many items remain, reads go out in groups of that length carrying that code on `bus_burst`. When fewer items remain, each read is a single with code 00.
- R7: Each group's reads all complete before its writes start, and the group has as many writes as reads. Write data follows read order, and every write carries burst code 00.
- R8: While `bus_req` is high and `bus_ready` is low, the request, direction and address hold unchanged into the next cycle, unless an abort occurs.
- R9: A control write with bit 0 clear while bit 0 reads 1 clears bit 0 and both working address registers at that edge. `bus_req` is low from the next cycle.
- R10: A start attempt with width code 11 in either width field issues no bus request and leaves bit 0 at 0. It sets `err_flag`, which then stays set until reset.
- R11: While bit 0 reads 1, a control write with bit 0 set is ignored: the control readback and the transfer in progress are unchanged.
- R12: A start attempt with an item count of zero leaves bit 0 at 0 and issues no bus request.
- R13: After reset, the control readback, `err_flag`, both working addresses and `bus_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 source start, 2 destination start, 3 item count) |
| reg_wdata | input | ADDR_W | Register write data |
| ctrl_q | output | 9 | Control word readback, bit 0 live run state |
| err_flag | output | 1 | Sticky illegal-width flag |
| cur_src_addr | output | ADDR_W | Working source address |
| cur_dst_addr | output | ADDR_W | Working destination address |
| bus_req | output | 1 | Transfer request |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | Item width code |
| bus_burst | output | 2 | Burst group code |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Transfer accepted this cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready on a read |

## Verification
Two events can land in the same cycle: a software abort and a bus acceptance. The bench raises `bus_ready` for a pending read or write and, in that same cycle, writes the control word with bit 0 clear. It then judges at the next sample that the run bit is 0, that both working addresses are zero and that no request remains. A later fresh transfer must then run cleanly from its start addresses. The same pairing is used for an ignored control write that lands on a read acceptance; here the readback must be unchanged and every following beat must still match the original settings.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int CTRL_W    = 9;
  localparam int MAX_BEATS = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_READ,
    S_WPREP,
    S_WRITE
  } seq_state_e;

  // Packed so that bit 0 is run and bits 8:7 are the burst group.
  typedef struct packed {
    logic [1:0] burst;
    logic [1:0] dsz;
    logic [1:0] ssz;
    logic       dinc;
    logic       sinc;
    logic       en;
  } ctrl_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic size_legal(input logic [1:0] code);
    return code != 2'b11;
  endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              seq_done,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [CNT_W-1:0]  max_cnt,
  output logic              start,
  output logic              abort,
  output logic              err_flag
);

  ctrl_t wr_ctrl;
  logic  ctrl_wr;
  logic  widths_ok;
  logic  bad_start;

  always_comb begin
    wr_ctrl   = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    ctrl_wr   = reg_we && (reg_sel == 2'd0);
    widths_ok = size_legal(wr_ctrl.ssz) && size_legal(wr_ctrl.dsz);
    start     = ctrl_wr && !ctrl.en && wr_ctrl.en && widths_ok && (max_cnt != '0);
    bad_start = ctrl_wr && !ctrl.en && wr_ctrl.en && !widths_ok;
    abort     = ctrl_wr && ctrl.en && !wr_ctrl.en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      err_flag <= 1'b0;
    end else begin
      if (ctrl_wr && !ctrl.en) begin
        ctrl    <= wr_ctrl;
        ctrl.en <= start;
      end else if (abort) begin
        ctrl <= wr_ctrl;
      end else if (seq_done) begin
        ctrl.en <= 1'b0;
      end
      if (bad_start) err_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base <= '0;
      dst_base <= '0;
      max_cnt  <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd1:    src_base <= reg_wdata;
        2'd2:    dst_base <= reg_wdata;
        2'd3:    max_cnt  <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              inc_en,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] stride;

  always_comb stride = ADDR_W'(size_bytes(size));

  always_ff @(posedge clk) begin
    if (rst || clr)              addr <= '0;
    else if (load)               addr <= load_val;
    else if (step && inc_en)     addr <= addr + stride;
  end

endmodule

// File: rtl/dma_beat_buf.sv
module dma_beat_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dma_seq_core.sv
module dma_seq_core
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [1:0]       burst_code,
  input  logic [CNT_W-1:0] max_cnt,
  input  logic             bus_ready,
  output logic             in_read,
  output logic             in_write,
  output logic             rd_acc,
  output logic             wr_acc,
  output logic             done,
  output logic [1:0]       chunk_code,
  output logic [IDX_W-1:0] buf_waddr,
  output logic [IDX_W-1:0] buf_raddr
);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W:0]   blen;
  logic [IDX_W-1:0] ridx;
  logic [IDX_W-1:0] widx;
  logic [1:0]       bcode;
  logic [4:0]       beats;
  logic             full_group;
  logic             last_rd;
  logic             last_wr;

  always_comb begin
    in_read    = (state == S_READ);
    in_write   = (state == S_WRITE);
    rd_acc     = in_read && bus_ready;
    wr_acc     = in_write && bus_ready;
    beats      = burst_beats(burst_code);
    full_group = int'(cnt) >= int'(beats);
    last_rd    = ({1'b0, ridx} == blen - 1'b1);
    last_wr    = ({1'b0, widx} == blen - 1'b1);
    done       = wr_acc && (cnt == CNT_W'(1));
    chunk_code = in_read ? bcode : 2'b00;
    buf_waddr  = ridx;
    // Prefetch the next beat so write data is ready the cycle after acceptance.
    buf_raddr  = wr_acc ? widx + 1'b1 : widx;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state <= S_IDLE;
      cnt   <= '0;
      blen  <= '0;
      ridx  <= '0;
      widx  <= '0;
      bcode <= 2'b00;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            cnt   <= max_cnt;
            state <= S_SETUP;
          end
        end
        S_SETUP: begin
          ridx <= '0;
          widx <= '0;
          if (full_group) begin
            blen  <= (IDX_W+1)'(beats);
            bcode <= burst_code;
          end else begin
            blen  <= (IDX_W+1)'(1);
            bcode <= 2'b00;
          end
          state <= S_READ;
        end
        S_READ: begin
          if (bus_ready) begin
            ridx <= ridx + 1'b1;
            if (last_rd) state <= S_WPREP;
          end
        end
        S_WPREP: state <= S_WRITE;
        S_WRITE: begin
          if (bus_ready) begin
            cnt  <= cnt - 1'b1;
            widx <= widx + 1'b1;
            if (cnt == CNT_W'(1)) state <= S_IDLE;
            else if (last_wr)     state <= S_SETUP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BUF_DEPTH = MAX_BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [8:0]        ctrl_q,
  output logic              err_flag,
  output logic [ADDR_W-1:0] cur_src_addr,
  output logic [ADDR_W-1:0] cur_dst_addr,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [1:0]        bus_burst,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int IDX_W = $clog2(BUF_DEPTH);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] src_base;
  logic [ADDR_W-1:0] dst_base;
  logic [CNT_W-1:0]  max_cnt;
  logic              start;
  logic              abort;
  logic              done;
  logic              in_read;
  logic              in_write;
  logic              rd_acc;
  logic              wr_acc;
  logic [1:0]        chunk_code;
  logic [IDX_W-1:0]  buf_waddr;
  logic [IDX_W-1:0]  buf_raddr;

  dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .seq_done (done),
    .ctrl     (ctrl),
    .src_base (src_base),
    .dst_base (dst_base),
    .max_cnt  (max_cnt),
    .start    (start),
    .abort    (abort),
    .err_flag (err_flag)
  );

  dma_seq_core #(.CNT_W(CNT_W), .DEPTH(BUF_DEPTH)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (abort),
    .burst_code(ctrl.burst),
    .max_cnt   (max_cnt),
    .bus_ready (bus_ready),
    .in_read   (in_read),
    .in_write  (in_write),
    .rd_acc    (rd_acc),
    .wr_acc    (wr_acc),
    .done      (done),
    .chunk_code(chunk_code),
    .buf_waddr (buf_waddr),
    .buf_raddr (buf_raddr)
  );

  dma_addr_ctr #(.ADDR_W(ADDR_W)) u_src_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (abort),
    .load    (start),
    .load_val(src_base),
    .step    (rd_acc),
    .inc_en  (ctrl.sinc),
    .size    (ctrl.ssz),
    .addr    (cur_src_addr)
  );

  dma_addr_ctr #(.ADDR_W(ADDR_W)) u_dst_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (abort),
    .load    (start),
    .load_val(dst_base),
    .step    (wr_acc),
    .inc_en  (ctrl.dinc),
    .size    (ctrl.dsz),
    .addr    (cur_dst_addr)
  );

  dma_beat_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk  (clk),
    .we   (rd_acc),
    .waddr(buf_waddr),
    .wdata(bus_rdata),
    .raddr(buf_raddr),
    .rdata(bus_wdata)
  );

  always_comb begin
    ctrl_q    = ctrl;
    bus_req   = in_read || in_write;
    bus_write = in_write;
    bus_addr  = in_write ? cur_dst_addr : cur_src_addr;
    bus_size  = in_write ? ctrl.dsz : ctrl.ssz;
    bus_burst = chunk_code;
  end

endmodule

// File: rtl/dma_stream_seq_chk.sv
module dma_stream_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_wr,
  input logic              ctl_wr_run,
  input logic              ctl_wr_bad,
  input logic [8:0]        ctrl_q,
  input logic              err_flag,
  input logic [ADDR_W-1:0] cur_src_addr,
  input logic [ADDR_W-1:0] cur_dst_addr,
  input logic              bus_req,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_burst,
  input logic              bus_ready
);

  logic [ADDR_W-1:0] src_stride;
  logic [ADDR_W-1:0] dst_stride;

  always_comb begin
    src_stride = ctrl_q[1] ? ADDR_W'(size_bytes(ctrl_q[4:3])) : '0;
    dst_stride = ctrl_q[2] ? ADDR_W'(size_bytes(ctrl_q[6:5])) : '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |-> !bus_req); // R2

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_write && bus_ready && !ctl_wr) |=>
      cur_src_addr == $past(cur_src_addr) + src_stride); // R3

  AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_write && bus_ready && !ctl_wr) |=>
      cur_dst_addr == $past(cur_dst_addr) + dst_stride); // R4

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_write) |-> bus_burst == 2'b00); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready && !ctl_wr) |=>
      bus_req && $stable(bus_write) && $stable(bus_addr)); // R8

  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && ctl_wr && !ctl_wr_run) |=>
      !ctrl_q[0] && cur_src_addr == '0 && cur_dst_addr == '0 && !bus_req); // R9

  AST_BAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[0] && ctl_wr && ctl_wr_run && ctl_wr_bad) |=>
      !ctrl_q[0] && err_flag); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R10

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && ctl_wr && ctl_wr_run) |=> ctrl_q[8:1] == $past(ctrl_q[8:1])); // R11

endmodule

bind dma_stream_seq dma_stream_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_wr      (reg_we && (reg_sel == 2'd0)),
  .ctl_wr_run  (reg_wdata[0]),
  .ctl_wr_bad  ((reg_wdata[4:3] == 2'b11) || (reg_wdata[6:5] == 2'b11)),
  .ctrl_q      (ctrl_q),
  .err_flag    (err_flag),
  .cur_src_addr(cur_src_addr),
  .cur_dst_addr(cur_dst_addr),
  .bus_req     (bus_req),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_burst   (bus_burst),
  .bus_ready   (bus_ready)
);

// File: tb/dma_stream_seq_test.sv
module dma_stream_seq_test;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [8:0]    ctrl_q;
  logic          err_flag;
  logic [AW-1:0] cur_src_addr;
  logic [AW-1:0] cur_dst_addr;
  logic          bus_req;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [1:0]    bus_burst;
  logic [DW-1:0] bus_wdata;
  logic          bus_ready = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int  n_vec  = 0;
  int  n_bad  = 0;
  int  run_id = 0;
  int  cyc    = 0;
  bit  summary_done = 1'b0;

  always #4 clk = ~clk;

  dma_stream_seq uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .err_flag(err_flag), .cur_src_addr(cur_src_addr),
    .cur_dst_addr(cur_dst_addr), .bus_req(bus_req), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_burst(bus_burst),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s run=%0d actual=%0h expected=%0h", req, what, run_id, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  endtask

  function automatic int nbytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic int nbeats(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
  endfunction

  function automatic logic [31:0] item_data(input int run, input int idx);
    return 32'h5A5A_0000 ^ {run[15:0], 16'h0} ^ 32'(idx * 32'h0000_0101);
  endfunction

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_wdata = data;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    reg_we = 1'b0;
    bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // mode 0: plain run; mode 1: busy control write on 2nd read; mode 2: abort at acceptance k
  task automatic run_xfer(input int ssz, input int dsz, input int sinc, input int dinc,
                          input int burst, input int cnt, input int mode, input int k);
    logic [31:0] src, dst, word;
    int rem, rd_n, wr_n, acc_n, rd_left, wr_left, chunk, ccode, iter;
    bit need_chunk, held, exp_wr, ok, aborting;
    logic [31:0] held_addr, exp_addr;
    run_id++;
    src  = 32'h1000_0000 + 32'(run_id * 32'h100);
    dst  = 32'h8000_0000 + 32'(run_id * 32'h100);
    word = 32'(burst << 7 | dsz << 5 | ssz << 3 | dinc << 2 | sinc << 1 | 1);
    reg_wr(2'd1, src);
    reg_wr(2'd2, dst);
    reg_wr(2'd3, 32'(cnt));
    reg_wr(2'd0, word);
    check(ctrl_q == word[8:0] && cur_src_addr == src && cur_dst_addr == dst,
          "R1", "start load", longint'(cur_src_addr), longint'(src));
    rem = cnt; rd_n = 0; wr_n = 0; acc_n = 0; rd_left = 0; wr_left = 0;
    chunk = 0; ccode = 0; need_chunk = 1'b1; held = 1'b0; held_addr = '0;
    aborting = 1'b0;
    for (iter = 0; iter < 4000; iter++) begin
      if (!ctrl_q[0]) break;
      if (held)
        check(bus_req && bus_addr == held_addr, "R8", "held request",
              longint'(bus_addr), longint'(held_addr));
      held = 1'b0;
      bus_ready = 1'b0;
      if (bus_req) begin
        cyc++;
        bus_ready = ((cyc % 5) != 2);
        if (!bus_ready) begin
          held = 1'b1;
          held_addr = bus_addr;
        end else begin
          if (need_chunk) begin
            chunk = (rem >= nbeats(burst)) ? nbeats(burst) : 1;
            ccode = (rem >= nbeats(burst)) ? burst : 0;
            rd_left = chunk; wr_left = chunk; need_chunk = 1'b0;
          end
          exp_wr = (rd_left == 0);
          check(bus_write == exp_wr, "R7", "direction", longint'(bus_write), longint'(exp_wr));
          if (!bus_write) begin
            bus_rdata = item_data(run_id, rd_n);
            exp_addr = src + 32'(sinc != 0 ? rd_n * nbytes(ssz) : 0);
            ok = bus_addr == exp_addr && int'(bus_size) == ssz && int'(bus_burst) == ccode;
            check(ok, "R3/R5/R6", "read beat", longint'({bus_size, bus_burst, bus_addr}),
                  longint'({2'(ssz), 2'(ccode), exp_addr}));
            if (mode == 1 && rd_n == 1) begin
              reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = word ^ 32'h1E6;
            end
            rd_n++; rd_left--;
          end else begin
            exp_addr = dst + 32'(dinc != 0 ? wr_n * nbytes(dsz) : 0);
            ok = bus_addr == exp_addr && int'(bus_size) == dsz && bus_burst == 2'b00 &&
                 bus_wdata == item_data(run_id, wr_n);
            check(ok, "R4/R5/R7", "write beat", longint'(bus_wdata),
                  longint'(item_data(run_id, wr_n)));
            wr_n++; wr_left--; rem--;
            if (wr_left == 0) need_chunk = 1'b1;
          end
          if (mode == 2 && acc_n == k) begin
            reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = word & ~32'h1;
            aborting = 1'b1;
          end
          acc_n++;
        end
      end
      @(negedge clk);
      if (reg_we && mode == 1)
        check(ctrl_q == word[8:0], "R11", "busy write ignored", longint'(ctrl_q), longint'(word[8:0]));
      reg_we = 1'b0;
      if (aborting) begin
        bus_ready = 1'b0;
        check(!ctrl_q[0] && !bus_req && cur_src_addr == '0 && cur_dst_addr == '0,
              "R9", "abort state", longint'({ctrl_q[0], bus_req, cur_src_addr}), 0);
        for (int q = 0; q < 8; q++) begin
          @(negedge clk);
          check(!bus_req && !ctrl_q[0], "R9", "quiet after abort", longint'(bus_req), 0);
        end
        return;
      end
    end
    bus_ready = 1'b0;
    check(rd_n == cnt && wr_n == cnt && !bus_req && !ctrl_q[0], "R2", "completion",
          longint'({rd_n[15:0], wr_n[15:0]}), longint'({cnt[15:0], cnt[15:0]}));
    exp_addr = src + 32'(sinc != 0 ? cnt * nbytes(ssz) : 0);
    check(cur_src_addr == exp_addr, "R3", "final source", longint'(cur_src_addr), longint'(exp_addr));
    exp_addr = dst + 32'(dinc != 0 ? cnt * nbytes(dsz) : 0);
    check(cur_dst_addr == exp_addr, "R4", "final dest", longint'(cur_dst_addr), longint'(exp_addr));
  endtask

  task automatic expect_no_start(input string req);
    for (int q = 0; q < 6; q++) begin
      check(!bus_req && !ctrl_q[0], req, "no start", longint'({ctrl_q[0], bus_req}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int counts [4] = '{1, 4, 6, 17};
    do_reset();
    check(ctrl_q == '0 && !err_flag && !bus_req && cur_src_addr == '0 && cur_dst_addr == '0,
          "R13", "reset state", longint'({ctrl_q, err_flag, bus_req}), 0);

    // Sweep widths, walk enables, burst codes and counts (R1 to R7)
    for (int s = 0; s < 3; s++)
      for (int inc = 0; inc < 4; inc++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++)
            run_xfer(s, (s + inc) % 3, inc & 1, inc >> 1, b, counts[c], 0, 0);

    // R11: control write while running is ignored
    run_xfer(2, 1, 1, 1, 1, 9, 1, 0);

    // R9: abort coinciding with a read acceptance, then with a write acceptance
    run_xfer(0, 0, 1, 1, 1, 17, 2, 2);
    run_xfer(2, 2, 1, 0, 1, 17, 2, 13);
    run_xfer(1, 1, 1, 1, 2, 10, 0, 0);

    // R12: zero item count
    reg_wr(2'd3, 32'd0);
    reg_wr(2'd0, 32'h0000_0007);
    expect_no_start("R12");

    // R10: reserved width codes in each field
    reg_wr(2'd3, 32'd5);
    reg_wr(2'd0, 32'h0000_0019);
    check(err_flag && !ctrl_q[0], "R10", "bad source width", longint'({err_flag, ctrl_q[0]}), 2);
    expect_no_start("R10");
    run_xfer(1, 2, 1, 1, 0, 3, 0, 0);
    check(err_flag, "R10", "flag sticky", longint'(err_flag), 1);
    do_reset();
    check(!err_flag && ctrl_q == '0, "R13", "flag cleared by reset", longint'(err_flag), 0);
    reg_wr(2'd3, 32'd5);
    reg_wr(2'd0, 32'h0000_0061);
    check(err_flag && !ctrl_q[0], "R10", "bad dest width", longint'({err_flag, ctrl_q[0]}), 2);
    expect_no_start("R10");

    finish_up();
  end

endmodule